// File: doc/BRIEF.md
# Vector Lane Predicate Mask Unit

This block tells a 128-bit vector datapath which of its sixteen byte lanes may be written by the current instruction. It holds the predicate state (a 16-bit per-byte predicate plus a 4-bit block-mask field for each 8-lane half) and an 8-bit condition/beat code. From that state, together with the loop element-size code and the remaining loop count supplied by the core, it forms one combinational lane-enable mask. Bit i of the mask enables byte lane i. Lanes handling 16-bit elements look at the even bits and lanes handling 32-bit elements look at bits 0, 4, 8 and 12.

Three effects are combined into the mask. First, a half whose block-mask field is zero is fully enabled, whatever its predicate bits hold. Second, on the final loop iteration, tail lanes past the remaining elements are cut off. Third, beats that finished before an interrupt are suppressed so that they are not executed again on resume. When the core strobes instruction completion, the block advances its own state: the block-mask fields shift, the predicate halves may be inverted, and the beat code steps. The core can also load the whole state directly, for example on exception return.

Top module: `lane_pred_unit`

## Requirements
- R1: After reset the predicate, both block-mask fields and the condition/beat code read zero, `badBeat` is 0, and with `sizeCode` of 4 or more `laneMask` is 16'hFFFF.
- R2: The base mask is the stored predicate, except that bits 7:0 are all ones when the low block-mask field is zero and bits 15:8 are all ones when the high field is zero.
- R3: When `sizeCode` is below 4 and `loopCount` is at most 16 >> `sizeCode`, only the low (`loopCount` << `sizeCode`) mask bits are kept and all higher bits read 0. A count of zero therefore gives an all-zero mask.
- R4: When bits 3:0 of the condition/beat code are zero, bits 7:4 hold a beat code. The code values and the mask bits they clear are: 0 clears none, 1 clears 3:0, 2 clears 7:0, and both 4 and 5 clear 11:0.
- R5: When bits 3:0 are zero and the beat code is anything other than 0, 1, 2, 4 or 5, `badBeat` is 1 and the code clears no bits. When bits 3:0 are nonzero, no beat clearing applies and `badBeat` is 0.
- R6: On an instruction-complete strobe, if bits 3:0 of the condition/beat code are zero, the code becomes 8'h10 when it was 8'h50 and becomes 8'h00 otherwise. If bits 3:0 are nonzero, the code is kept.
- R7: On an instruction-complete strobe with both block-mask fields zero, the predicate and both fields are left unchanged.
- R8: On an instruction-complete strobe with at least one field nonzero, a field whose value is above 8 inverts its own 8-bit half of the predicate (low field: bits 7:0, high field: bits 15:8).
- R9: On an instruction-complete strobe, each block-mask field is shifted left by one bit and truncated to 4 bits.
- R10: A write strobe loads the predicate, both fields and the condition/beat code on the next clock edge, and takes priority over a simultaneous instruction-complete strobe.
- R11: With neither strobe asserted, the stored state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Load the state from the write inputs |
| wrPred | input | 16 | Predicate value to load |
| wrLoField | input | 4 | Low-half block-mask field to load |
| wrHiField | input | 4 | High-half block-mask field to load |
| wrCondBeat | input | 8 | Condition/beat code to load |
| instrDone | input | 1 | Instruction-complete strobe; advances the state |
| sizeCode | input | 3 | Loop element-size code (log2 bytes); 4 or more disables tail masking |
| loopCount | input | 32 | Remaining loop element count |
| laneMask | output | 16 | Per-byte lane enable |
| predOut | output | 16 | Stored predicate |
| loFieldOut | output | 4 | Stored low-half block-mask field |
| hiFieldOut | output | 4 | Stored high-half block-mask field |
| condBeatOut | output | 8 | Stored condition/beat code |
| badBeat | output | 1 | Stored beat code is not a legal encoding |

## Verification
The properties assume that `wrEn` and `instrDone` are clean single-cycle-qualified strobes, sampled only at clock edges. They also assume that when a write and a completion coincide, the write alone decides the next state, so the update checks are gated on `wrEn` being low. The tail property assumes `sizeCode` and `loopCount` are stable levels that drive the mask through combinational logic only. The stimulus therefore changes them only between edges, while both strobes are idle, and it always raises and drops the strobes on the falling edge.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  // strobes handed from control to datapath
  typedef struct packed {
    logic [1:0] clrBeats;  // number of leading 4-lane beats to suppress
    logic       invLo;     // invert predicate bits of low half on completion
    logic       invHi;     // invert predicate bits of high half on completion
  } ctrlStrobe_t;

  localparam logic [3:0] BEAT_NONE   = 4'd0;
  localparam logic [3:0] BEAT_ONE    = 4'd1;
  localparam logic [3:0] BEAT_TWO    = 4'd2;
  localparam logic [3:0] BEAT_THREE  = 4'd4;
  localparam logic [3:0] BEAT_THREEB = 4'd5;
endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int FIELD_W = 4,
  parameter int COND_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [FIELD_W-1:0] wrLoField,
  input  logic [FIELD_W-1:0] wrHiField,
  input  logic [COND_W-1:0]  wrCondBeat,
  input  logic               instrDone,
  output lpm_pkg::ctrlStrobe_t strobe,
  output logic [FIELD_W-1:0] loField,
  output logic [FIELD_W-1:0] hiField,
  output logic [COND_W-1:0]  condBeat,
  output logic               badBeat
);
  import lpm_pkg::*;

  localparam int CODE_W = COND_W - 4;
  localparam logic [FIELD_W-1:0] INV_THRESH = FIELD_W'(1 << (FIELD_W - 1));

  logic              beatOn;
  logic [CODE_W-1:0] beatCode;
  logic              blockOn;
  logic [COND_W-1:0] condNext;

  assign beatOn   = (condBeat[3:0] == 4'd0);
  assign beatCode = condBeat[COND_W-1:4];
  assign blockOn  = (loField != '0) || (hiField != '0);

  always_comb begin
    strobe.clrBeats = 2'd0;
    badBeat         = 1'b0;
    if (beatOn) begin
      case (beatCode)
        CODE_W'(BEAT_NONE):   strobe.clrBeats = 2'd0;
        CODE_W'(BEAT_ONE):    strobe.clrBeats = 2'd1;
        CODE_W'(BEAT_TWO):    strobe.clrBeats = 2'd2;
        CODE_W'(BEAT_THREE),
        CODE_W'(BEAT_THREEB): strobe.clrBeats = 2'd3;
        default:              badBeat = 1'b1;
      endcase
    end
    strobe.invLo = blockOn && (loField > INV_THRESH);
    strobe.invHi = blockOn && (hiField > INV_THRESH);
  end

  always_comb begin
    condNext = condBeat;
    if (beatOn) begin
      if (beatCode == CODE_W'(BEAT_THREEB)) condNext = COND_W'({CODE_W'(BEAT_ONE), 4'd0});
      else                                  condNext = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loField  <= '0;
      hiField  <= '0;
      condBeat <= '0;
    end else if (wrEn) begin
      loField  <= wrLoField;
      hiField  <= wrHiField;
      condBeat <= wrCondBeat;
    end else if (instrDone) begin
      condBeat <= condNext;
      if (blockOn) begin
        loField <= {loField[FIELD_W-2:0], 1'b0};
        hiField <= {hiField[FIELD_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/lpm_data.sv
module lpm_data #(
  parameter int LANES   = 16,
  parameter int FIELD_W = 4,
  parameter int CNT_W   = 32,
  parameter int SIZE_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [LANES-1:0]   wrPred,
  input  logic               instrDone,
  input  lpm_pkg::ctrlStrobe_t strobe,
  input  logic [FIELD_W-1:0] loField,
  input  logic [FIELD_W-1:0] hiField,
  input  logic [SIZE_W-1:0]  sizeCode,
  input  logic [CNT_W-1:0]   loopCount,
  output logic [LANES-1:0]   pred,
  output logic [LANES-1:0]   laneMask
);
  localparam int HALF     = LANES / 2;
  localparam int BEAT_W   = LANES / 4;
  localparam int LOG_L    = $clog2(LANES);
  localparam int LEN_W    = LOG_L + 1;

  logic [LANES-1:0] baseMask;
  logic             tailOn;
  logic [LEN_W-1:0] tailLen;
  logic [CNT_W-1:0] tailLimit;

  assign baseMask[HALF-1:0]     = (loField == '0) ? '1 : pred[HALF-1:0];
  assign baseMask[LANES-1:HALF] = (hiField == '0) ? '1 : pred[LANES-1:HALF];

  assign tailLimit = CNT_W'(LANES >> sizeCode);
  assign tailOn    = (sizeCode < SIZE_W'(LOG_L)) && (loopCount <= tailLimit);
  assign tailLen   = LEN_W'(loopCount[LEN_W-1:0] << sizeCode);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic keepTail;
    logic keepBeat;
    assign keepTail    = !tailOn || (LEN_W'(i) < tailLen);
    assign keepBeat    = !(2'(i / BEAT_W) < strobe.clrBeats);
    assign laneMask[i] = baseMask[i] && keepTail && keepBeat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pred <= '0;
    end else if (wrEn) begin
      pred <= wrPred;
    end else if (instrDone) begin
      pred <= pred ^ {{HALF{strobe.invHi}}, {HALF{strobe.invLo}}};
    end
  end
endmodule

// File: rtl/lane_pred_unit.sv
module lane_pred_unit #(
  parameter int LANES   = 16,
  parameter int FIELD_W = 4,
  parameter int COND_W  = 8,
  parameter int CNT_W   = 32,
  parameter int SIZE_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [LANES-1:0]   wrPred,
  input  logic [FIELD_W-1:0] wrLoField,
  input  logic [FIELD_W-1:0] wrHiField,
  input  logic [COND_W-1:0]  wrCondBeat,
  input  logic               instrDone,
  input  logic [SIZE_W-1:0]  sizeCode,
  input  logic [CNT_W-1:0]   loopCount,
  output logic [LANES-1:0]   laneMask,
  output logic [LANES-1:0]   predOut,
  output logic [FIELD_W-1:0] loFieldOut,
  output logic [FIELD_W-1:0] hiFieldOut,
  output logic [COND_W-1:0]  condBeatOut,
  output logic               badBeat
);
  lpm_pkg::ctrlStrobe_t strobe;

  lpm_ctrl #(.FIELD_W(FIELD_W), .COND_W(COND_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn),
    .wrLoField(wrLoField), .wrHiField(wrHiField), .wrCondBeat(wrCondBeat),
    .instrDone(instrDone), .strobe(strobe),
    .loField(loFieldOut), .hiField(hiFieldOut),
    .condBeat(condBeatOut), .badBeat(badBeat)
  );

  lpm_data #(.LANES(LANES), .FIELD_W(FIELD_W), .CNT_W(CNT_W), .SIZE_W(SIZE_W)) u_data (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrPred(wrPred),
    .instrDone(instrDone), .strobe(strobe),
    .loField(loFieldOut), .hiField(hiFieldOut),
    .sizeCode(sizeCode), .loopCount(loopCount),
    .pred(predOut), .laneMask(laneMask)
  );
endmodule

// File: rtl/lpm_checks.sv
module lpm_checks #(
  parameter int LANES   = 16,
  parameter int FIELD_W = 4,
  parameter int COND_W  = 8,
  parameter int CNT_W   = 32,
  parameter int SIZE_W  = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic               instrDone,
  input logic [SIZE_W-1:0]  sizeCode,
  input logic [CNT_W-1:0]   loopCount,
  input logic [LANES-1:0]   laneMask,
  input logic [LANES-1:0]   predOut,
  input logic [FIELD_W-1:0] loFieldOut,
  input logic [FIELD_W-1:0] hiFieldOut,
  input logic [COND_W-1:0]  condBeatOut,
  input logic               badBeat
);
  a_r3_zero_count_empty: assert property (@(posedge clk) disable iff (!rstN)
    (sizeCode < SIZE_W'(4) && loopCount == '0) |-> laneMask == '0);

  a_r4_two_beats_done: assert property (@(posedge clk) disable iff (!rstN)
    (condBeatOut == COND_W'(8'h20)) |-> laneMask[7:0] == 8'h00);

  a_r5_bad_needs_beat_field: assert property (@(posedge clk) disable iff (!rstN)
    badBeat |-> condBeatOut[3:0] == 4'd0);

  a_r6_beat_steps: assert property (@(posedge clk) disable iff (!rstN)
    (instrDone && !wrEn && condBeatOut[3:0] == 4'd0) |=>
      (condBeatOut == '0 || condBeatOut == COND_W'(8'h10)));

  a_r7_idle_pred: assert property (@(posedge clk) disable iff (!rstN)
    (instrDone && !wrEn && loFieldOut == '0 && hiFieldOut == '0) |=> $stable(predOut));

  a_r9_field_shift: assert property (@(posedge clk) disable iff (!rstN)
    (instrDone && !wrEn) |=>
      (loFieldOut == FIELD_W'($past(loFieldOut) << 1) &&
       hiFieldOut == FIELD_W'($past(hiFieldOut) << 1)));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!instrDone && !wrEn) |=>
      ($stable(predOut) && $stable(loFieldOut) && $stable(hiFieldOut) && $stable(condBeatOut)));
endmodule

bind lane_pred_unit lpm_checks #(
  .LANES(LANES), .FIELD_W(FIELD_W), .COND_W(COND_W), .CNT_W(CNT_W), .SIZE_W(SIZE_W)
) u_lpm_checks (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .instrDone(instrDone),
  .sizeCode(sizeCode), .loopCount(loopCount), .laneMask(laneMask),
  .predOut(predOut), .loFieldOut(loFieldOut), .hiFieldOut(hiFieldOut),
  .condBeatOut(condBeatOut), .badBeat(badBeat)
);

// File: tb/test_lane_pred_unit.sv
module test_lane_pred_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrPred = '0;
  logic [3:0]  wrLoField = '0;
  logic [3:0]  wrHiField = '0;
  logic [7:0]  wrCondBeat = '0;
  logic        instrDone = 1'b0;
  logic [2:0]  sizeCode = 3'd4;
  logic [31:0] loopCount = '0;
  logic [15:0] laneMask;
  logic [15:0] predOut;
  logic [3:0]  loFieldOut;
  logic [3:0]  hiFieldOut;
  logic [7:0]  condBeatOut;
  logic        badBeat;

  int nChecks = 0;
  int nFail = 0;

  always #(CLK_P/2) clk = ~clk;

  lane_pred_unit i_lane_pred_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrPred(wrPred),
    .wrLoField(wrLoField), .wrHiField(wrHiField), .wrCondBeat(wrCondBeat),
    .instrDone(instrDone), .sizeCode(sizeCode), .loopCount(loopCount),
    .laneMask(laneMask), .predOut(predOut), .loFieldOut(loFieldOut),
    .hiFieldOut(hiFieldOut), .condBeatOut(condBeatOut), .badBeat(badBeat)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic legalCode(logic [3:0] c);
    return c == 4'd0 || c == 4'd1 || c == 4'd2 || c == 4'd4 || c == 4'd5;
  endfunction

  function automatic logic [15:0] expMask(logic [15:0] p, logic [3:0] lo, logic [3:0] hi,
                                          int sz, int cnt, logic [7:0] cb);
    logic [15:0] m;
    m = p;
    if (lo == 0) m[7:0] = 8'hFF;
    if (hi == 0) m[15:8] = 8'hFF;
    if (sz < 4 && cnt <= (16 >> sz)) begin
      for (int i = 0; i < 16; i++) if (i >= cnt * (1 << sz)) m[i] = 1'b0;
    end
    if (cb[3:0] == 0) begin
      case (cb[7:4])
        4'd1: m = m & 16'hFFF0;
        4'd2: m = m & 16'hFF00;
        4'd4, 4'd5: m = m & 16'hF000;
        default: ;
      endcase
    end
    return m;
  endfunction

  task automatic writeState(logic [15:0] p, logic [3:0] lo, logic [3:0] hi, logic [7:0] cb);
    @(negedge clk);
    wrEn = 1'b1; wrPred = p; wrLoField = lo; wrHiField = hi; wrCondBeat = cb;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk);
    instrDone = 1'b1;
    @(negedge clk);
    instrDone = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: run did not finish");
    finishRun();
  end

  initial begin
    logic [15:0] preds [3];
    logic [3:0]  los [3];
    logic [3:0]  his [3];
    logic [7:0]  conds [18];
    preds = '{16'h0000, 16'h5A3C, 16'hFFFF};
    los   = '{4'd0, 4'd4, 4'd9};
    his   = '{4'd0, 4'd8, 4'd15};
    for (int k = 0; k < 16; k++) conds[k] = 8'(k << 4);
    conds[16] = 8'h03;
    conds[17] = 8'h28;

    // R1 reset state
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 pred", 32'(predOut), 0);
    chk("R1 lo", 32'(loFieldOut), 0);
    chk("R1 hi", 32'(hiFieldOut), 0);
    chk("R1 cond", 32'(condBeatOut), 0);
    chk("R1 bad", 32'(badBeat), 0);
    chk("R1 mask", 32'(laneMask), 32'hFFFF);

    // R2, R3, R4, R5 mask sweep
    foreach (preds[a]) foreach (los[b]) foreach (his[c]) foreach (conds[d]) begin
      writeState(preds[a], los[b], his[c], conds[d]);
      for (int sz = 0; sz <= 4; sz++) begin
        for (int cnt = 0; cnt <= 18; cnt++) begin
          string tag;
          sizeCode = 3'(sz);
          loopCount = 32'(cnt);
          #1;
          if (sz < 4 && cnt <= (16 >> sz)) tag = "R3 tail mask";
          else if (conds[d][3:0] == 0 && conds[d][7:4] != 0) tag = "R4 beat mask";
          else tag = "R2 base mask";
          chk(tag, 32'(laneMask),
              32'(expMask(preds[a], los[b], his[c], sz, cnt, conds[d])));
        end
      end
      chk("R5 bad flag", 32'(badBeat),
          32'(conds[d][3:0] == 0 && !legalCode(conds[d][7:4])));
    end
    sizeCode = 3'd4;
    loopCount = '0;

    // R6, R7, R8, R9 completion update over every field pair
    for (int lo = 0; lo < 16; lo++) begin
      for (int hi = 0; hi < 16; hi++) begin
        logic [7:0]  cb;
        logic [15:0] p;
        logic [15:0] expP;
        logic [7:0]  expC;
        logic [3:0]  expLo;
        logic [3:0]  expHi;
        cb = conds[(lo * 16 + hi) % 18];
        p  = 16'h3C5A ^ 16'(lo * 16'h0101 + hi);
        writeState(p, 4'(lo), 4'(hi), cb);
        pulseDone();
        #1;
        expP = p; expLo = 4'(lo); expHi = 4'(hi); expC = cb;
        if (cb[3:0] == 0) expC = (cb == 8'h50) ? 8'h10 : 8'h00;
        if (lo != 0 || hi != 0) begin
          if (lo > 8) expP = expP ^ 16'h00FF;
          if (hi > 8) expP = expP ^ 16'hFF00;
          expLo = 4'(lo << 1);
          expHi = 4'(hi << 1);
        end
        chk("R6 beat step", 32'(condBeatOut), 32'(expC));
        if (lo == 0 && hi == 0) chk("R7 idle pred", 32'(predOut), 32'(expP));
        else chk("R8 pred invert", 32'(predOut), 32'(expP));
        chk("R9 lo shift", 32'(loFieldOut), 32'(expLo));
        chk("R9 hi shift", 32'(hiFieldOut), 32'(expHi));
      end
    end

    // R10 write beats a simultaneous completion
    writeState(16'h1234, 4'd12, 4'd3, 8'h50);
    @(negedge clk);
    wrEn = 1'b1; instrDone = 1'b1;
    wrPred = 16'hBEEF; wrLoField = 4'd9; wrHiField = 4'd10; wrCondBeat = 8'h50;
    @(negedge clk);
    wrEn = 1'b0; instrDone = 1'b0;
    #1;
    chk("R10 pred", 32'(predOut), 32'hBEEF);
    chk("R10 lo", 32'(loFieldOut), 9);
    chk("R10 hi", 32'(hiFieldOut), 10);
    chk("R10 cond", 32'(condBeatOut), 32'h50);

    // R11 nothing moves without a strobe
    repeat (5) @(negedge clk);
    #1;
    chk("R11 pred", 32'(predOut), 32'hBEEF);
    chk("R11 lo", 32'(loFieldOut), 9);
    chk("R11 hi", 32'(hiFieldOut), 10);
    chk("R11 cond", 32'(condBeatOut), 32'h50);

    // R6 resume chain: 0x50 -> 0x10 -> 0x00
    pulseDone();
    #1;
    chk("R6 chain first", 32'(condBeatOut), 32'h10);
    pulseDone();
    #1;
    chk("R6 chain second", 32'(condBeatOut), 0);

    finishRun();
  end
endmodule